// File: doc/BRIEF.md
# L2 Table Access Command Controller

This block is the host-side access engine for a layer-2 forwarding table. The table has two regions: a hashed region arranged as buckets of four ways, and a small region that is addressed directly by index. Software moves one 96-bit row at a time through three 32-bit staging words and starts the transfer with a single command word. That word carries a start flag, the transfer direction, the region code and a row index.

To write a row, the host loads the three staging words and then issues a write command. To read a row, it issues a read command and collects the three staging words once the start flag has dropped. The start flag is cleared by hardware, so a polling loop on the command word is the only handshake needed. Hashing and the meaning of the fields inside a row are handled outside this block. For the hashed region, the caller passes an index already formed as bucket times four plus way.

Top module: `l2acc_table_ctrl`

## Requirements
- R1: After reset, the command word and all three staging words read as zero.
- R2: The command word layout is: bit 17 start flag, bit 16 direction (0 read, 1 write), bits 15:14 region code (00 hashed, 01 indexed), bits 13:0 row index. A command written with bit 17 clear is stored and read back unchanged in bits 16:0, and no access is started.
- R3: A command written with bit 17 set reads back with bit 17 high in the first and second cycles after the capturing clock edge. In the third cycle bit 17 reads low, and the other command fields are kept.
- R4: A write command stores staging word 0 as row bits 31:0, word 1 as bits 63:32 and word 2 as bits 95:64, and leaves the staging words unchanged.
- R5: A read command loads all three staging words with the addressed row, in the same word order as R4, before bit 17 drops.
- R6: In the hashed region, index bits 1:0 choose the way and the next bits choose the bucket. Every way of every bucket is a separate row.
- R7: In the indexed region only index bits 5:0 are used. Indices that differ only in bits 13:6 reach the same row.
- R8: The two regions are separate stores. A write to one region with a given index does not change the row at that index in the other region.
- R9: A row that has not been written since reset, or that was last written with all-zero data, reads as three zero words.
- R10: While bit 17 is high, host writes to the command word and to the staging words are ignored.
- R11: Region codes 10 and 11 complete with the same timing as R3, change no stored row, and a read with either code loads zeros into the staging words.
- R12: Command word bits 31:18 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe for the register selected by host_addr |
| host_addr | input | 2 | Register select: 0 command word, 1 to 3 staging words 0 to 2 |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the register selected by host_addr (combinational) |

## Verification
A wrong sequencer state shows at the command word within three cycles of a start. Either bit 17 stays high past its two-cycle window, or it drops early while the staging words are not yet loaded. A wrong way, bucket or region decode only shows on a later read, as a row that was lost, moved or shared. The bench therefore writes distinct patterns to neighbouring ways, to neighbouring buckets and to both regions, and reads each row back. Staging words that were changed while busy are caught on the first read of the staging words after the start flag drops.

// File: rtl/l2acc_pkg.sv
package l2acc_pkg;

    localparam int HOST_W    = 32;
    localparam int ROW_WORDS = 3;
    localparam int ROW_W     = HOST_W * ROW_WORDS;
    localparam int HADDR_W   = 2;
    localparam int IDX_W     = 14;
    localparam int CMD_W     = IDX_W + 4;
    localparam int EXEC_BIT  = 17;

    localparam logic [HADDR_W-1:0] HADDR_CMD = 2'd0;

    typedef enum logic [1:0] {
        RG_HASHED  = 2'b00,
        RG_INDEXED = 2'b01,
        RG_RSV2    = 2'b10,
        RG_RSV3    = 2'b11
    } region_e;

    typedef struct packed {
        logic             exec;
        logic             wr;
        region_e          region;
        logic [IDX_W-1:0] idx;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FINISH = 2'd2
    } state_e;

endpackage

// File: rtl/l2acc_row_bank.sv
module l2acc_row_bank #(
    parameter int AW    = 8,
    parameter int ROW_W = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             re_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [ROW_W-1:0] wdata_i,
    output logic [ROW_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [ROW_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0] vld_d, vld_q;
    logic [ROW_W-1:0] rdata_d, rdata_q;

    // Storage array carries no reset; the valid vector masks stale content.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    always_comb begin
        vld_d   = vld_q;
        rdata_d = '0;
        if (we_i) begin
            vld_d[addr_i] = |wdata_i;
        end
        if (re_i && vld_q[addr_i]) begin
            rdata_d = mem[addr_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q   <= '0;
            rdata_q <= '0;
        end else begin
            vld_q   <= vld_d;
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/l2acc_cmd_decode.sv
module l2acc_cmd_decode
    import l2acc_pkg::*;
#(
    parameter int SRAM_AW = 10,
    parameter int CAM_AW  = 6,
    parameter int WAYS    = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int ROW_AW = SRAM_AW - WAY_W
) (
    input  cmd_t              cmd_i,
    input  logic              active_i,
    output logic [WAYS-1:0]   sram_we_o,
    output logic [WAYS-1:0]   sram_re_o,
    output logic              cam_we_o,
    output logic              cam_re_o,
    output logic [ROW_AW-1:0] sram_row_o,
    output logic [CAM_AW-1:0] cam_row_o
);

    localparam int HI_USED = (SRAM_AW > CAM_AW) ? SRAM_AW : CAM_AW;

    logic             hit_hashed;
    logic             hit_indexed;
    logic [WAY_W-1:0] way;

    assign hit_hashed  = active_i && (cmd_i.region == RG_HASHED);
    assign hit_indexed = active_i && (cmd_i.region == RG_INDEXED);

    assign way        = cmd_i.idx[WAY_W-1:0];
    assign sram_row_o = cmd_i.idx[SRAM_AW-1:WAY_W];
    assign cam_row_o  = cmd_i.idx[CAM_AW-1:0];

    assign cam_we_o = hit_indexed &&  cmd_i.wr;
    assign cam_re_o = hit_indexed && !cmd_i.wr;

    for (genvar g = 0; g < WAYS; g++) begin : g_way_sel
        assign sram_we_o[g] = hit_hashed &&  cmd_i.wr && (way == WAY_W'(g));
        assign sram_re_o[g] = hit_hashed && !cmd_i.wr && (way == WAY_W'(g));
    end

    logic unused_exec;
    assign unused_exec = cmd_i.exec;

    if (HI_USED < IDX_W) begin : g_hi_idx
        logic unused_hi_idx;
        assign unused_hi_idx = ^cmd_i.idx[IDX_W-1:HI_USED];
    end

endmodule

// File: rtl/l2acc_table_ctrl.sv
module l2acc_table_ctrl
    import l2acc_pkg::*;
#(
    parameter int SRAM_AW = 10,
    parameter int CAM_AW  = 6,
    parameter int WAYS    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);

    localparam int WAY_W  = $clog2(WAYS);
    localparam int ROW_AW = SRAM_AW - WAY_W;

    typedef struct packed {
        state_e                            state;
        cmd_t                              cmd;
        logic [ROW_WORDS-1:0][HOST_W-1:0]  data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WAYS-1:0]              sram_we, sram_re;
    logic                         cam_we, cam_re;
    logic [ROW_AW-1:0]            sram_row;
    logic [CAM_AW-1:0]            cam_row;
    logic [WAYS-1:0][ROW_W-1:0]   way_rd;
    logic [ROW_W-1:0]             cam_rd;
    logic [ROW_W-1:0]             rd_row;
    logic [ROW_W-1:0]             wr_row;
    logic                         in_access;

    assign in_access = (ctl_q.state == ST_ACCESS);
    assign wr_row    = ctl_q.data;

    l2acc_cmd_decode #(
        .SRAM_AW (SRAM_AW),
        .CAM_AW  (CAM_AW),
        .WAYS    (WAYS)
    ) u_decode (
        .cmd_i      (ctl_q.cmd),
        .active_i   (in_access),
        .sram_we_o  (sram_we),
        .sram_re_o  (sram_re),
        .cam_we_o   (cam_we),
        .cam_re_o   (cam_re),
        .sram_row_o (sram_row),
        .cam_row_o  (cam_row)
    );

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        l2acc_row_bank #(
            .AW    (ROW_AW),
            .ROW_W (ROW_W)
        ) u_way_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (sram_we[g]),
            .re_i    (sram_re[g]),
            .addr_i  (sram_row),
            .wdata_i (wr_row),
            .rdata_o (way_rd[g])
        );
    end

    l2acc_row_bank #(
        .AW    (CAM_AW),
        .ROW_W (ROW_W)
    ) u_cam_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cam_we),
        .re_i    (cam_re),
        .addr_i  (cam_row),
        .wdata_i (wr_row),
        .rdata_o (cam_rd)
    );

    // Idle banks return zero, so the selected row is the OR of all outputs.
    always_comb begin
        rd_row = cam_rd;
        for (int w = 0; w < WAYS; w++) begin
            rd_row = rd_row | way_rd[w];
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (host_we) begin
                    if (host_addr == HADDR_CMD) begin
                        ctl_d.cmd = cmd_t'(host_wdata[CMD_W-1:0]);
                        if (host_wdata[EXEC_BIT]) begin
                            ctl_d.state = ST_ACCESS;
                        end
                    end else begin
                        for (int i = 0; i < ROW_WORDS; i++) begin
                            if (host_addr == HADDR_W'(i + 1)) begin
                                ctl_d.data[i] = host_wdata;
                            end
                        end
                    end
                end
            end
            ST_ACCESS: begin
                ctl_d.state = ST_FINISH;
            end
            ST_FINISH: begin
                if (!ctl_q.cmd.wr) begin
                    for (int i = 0; i < ROW_WORDS; i++) begin
                        ctl_d.data[i] = rd_row[i*HOST_W +: HOST_W];
                    end
                end
                ctl_d.cmd.exec = 1'b0;
                ctl_d.state    = ST_IDLE;
            end
            default: begin
                ctl_d.state    = ST_IDLE;
                ctl_d.cmd.exec = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == HADDR_CMD) begin
            host_rdata[CMD_W-1:0] = ctl_q.cmd;
        end else begin
            for (int i = 0; i < ROW_WORDS; i++) begin
                if (host_addr == HADDR_W'(i + 1)) begin
                    host_rdata = ctl_q.data[i];
                end
            end
        end
    end

    // Plain views of internal state for the bound checker.
    logic             chk_exec;
    logic             chk_wr;
    logic [1:0]       chk_region;
    logic [CMD_W-2:0] chk_fields;
    logic [ROW_W-1:0] chk_data;
    logic             chk_mem_we;
    logic [WAYS:0]    chk_bank_re;

    assign chk_exec    = ctl_q.cmd.exec;
    assign chk_wr      = ctl_q.cmd.wr;
    assign chk_region  = ctl_q.cmd.region;
    assign chk_fields  = ctl_q.cmd[CMD_W-2:0];
    assign chk_data    = ctl_q.data;
    assign chk_mem_we  = (|sram_we) | cam_we;
    assign chk_bank_re = {cam_re, sram_re};

endmodule

// File: rtl/l2acc_table_ctrl_chk.sv
module l2acc_table_ctrl_chk #(
    parameter int WAYS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        exec_q,
    input logic        wr_q,
    input logic [1:0]  region_q,
    input logic [16:0] fields_q,
    input logic [95:0] data_q,
    input logic        in_access,
    input logic        mem_we,
    input logic [WAYS:0] bank_re
);

    assert_exec_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exec_q) |=> exec_q);

    assert_exec_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_q && $past(exec_q)) |=> !exec_q);

    assert_write_keeps_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_q && wr_q) |=> $stable(data_q));

    assert_busy_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |=> $stable(fields_q));

    assert_busy_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_q && in_access) |=> $stable(data_q));

    assert_no_reserved_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (in_access && wr_q && !region_q[1]));

    assert_single_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_re));

endmodule

bind l2acc_table_ctrl l2acc_table_ctrl_chk #(.WAYS(WAYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_q    (chk_exec),
    .wr_q      (chk_wr),
    .region_q  (chk_region),
    .fields_q  (chk_fields),
    .data_q    (chk_data),
    .in_access (in_access),
    .mem_we    (chk_mem_we),
    .bank_re   (chk_bank_re)
);

// File: tb/l2acc_table_ctrl_tb.sv
module l2acc_table_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_we;
    logic [1:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;

    always #5 clk = ~clk;

    l2acc_table_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        samp = 1'b0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          finished = 1'b0;

    // Monitor: pops the expected word and compares away from the clock edge.
    always @(negedge clk) begin
        if (samp) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (host_rdata !== e) begin
                n_err++;
                $display("FAIL %s: got %h expected %h", t, host_rdata, e);
            end
        end
    end

    function automatic logic [31:0] mk(input bit ex, input bit w, input int rg, input int idx);
        return (32'(ex) << 17) | (32'(w) << 16) | (32'(rg & 3) << 14) | 32'(idx & 16'h3fff);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        host_we    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        tick();
        host_we    = 1'b0;
    endtask

    task automatic chk(input logic [1:0] a, input logic [31:0] e, input string t);
        host_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        samp = 1'b1;
        tick();
        samp = 1'b0;
    endtask

    task automatic load(input logic [31:0] d0, input logic [31:0] d1, input logic [31:0] d2);
        wr(2'd1, d0);
        wr(2'd2, d1);
        wr(2'd3, d2);
    endtask

    task automatic expect_row(input logic [31:0] d0, input logic [31:0] d1,
                              input logic [31:0] d2, input string t);
        chk(2'd1, d0, t);
        chk(2'd2, d1, t);
        chk(2'd3, d2, t);
    endtask

    task automatic run(input logic [31:0] c);
        wr(2'd0, c);
        tick();
        tick();
    endtask

    task automatic run_timed(input logic [31:0] c, input string t);
        wr(2'd0, c);
        chk(2'd0, c, t);
        chk(2'd0, c, t);
        chk(2'd0, c & ~32'h0002_0000, t);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        host_we    = 1'b0;
        host_addr  = 2'd0;
        host_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int a = 0; a < 4; a++) chk(2'(a), 32'h0, "R1 reset value");

        // R2 / R12: command stored without start, upper bits read zero
        wr(2'd0, 32'hFFFD_FFFF);
        chk(2'd0, 32'h0001_FFFF, "R2 R12 command readback");
        expect_row(32'h0, 32'h0, 32'h0, "R2 no access without start");

        // R3 / R4: hashed write bucket 5 way 2 with timing
        load(32'hA000_0001, 32'hA000_0002, 32'hA000_0003);
        run_timed(mk(1, 1, 0, (5 << 2) | 2), "R3 write timing");
        expect_row(32'hA000_0001, 32'hA000_0002, 32'hA000_0003, "R4 staging kept");

        // R6: neighbouring way and neighbouring bucket
        load(32'hB000_0001, 32'hB000_0002, 32'hB000_0003);
        run(mk(1, 1, 0, (5 << 2) | 1));
        load(32'hC000_0001, 32'hC000_0002, 32'hC000_0003);
        run(mk(1, 1, 0, (6 << 2) | 2));

        // R5 / R3: reads with timing and word order
        run_timed(mk(1, 0, 0, (5 << 2) | 2), "R3 read timing");
        expect_row(32'hA000_0001, 32'hA000_0002, 32'hA000_0003, "R5 R6 bucket5 way2");
        run(mk(1, 0, 0, (5 << 2) | 1));
        expect_row(32'hB000_0001, 32'hB000_0002, 32'hB000_0003, "R6 bucket5 way1");
        run(mk(1, 0, 0, (6 << 2) | 2));
        expect_row(32'hC000_0001, 32'hC000_0002, 32'hC000_0003, "R6 bucket6 way2");

        // R9: never-written row reads zero
        load(32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
        run(mk(1, 0, 0, 100));
        expect_row(32'h0, 32'h0, 32'h0, "R9 unwritten hashed row");

        // R7 / R8: indexed region
        load(32'hD000_0001, 32'hD000_0002, 32'hD000_0003);
        run(mk(1, 1, 1, 5));
        load(32'h0, 32'h0, 32'h0);
        run(mk(1, 0, 1, 32'h45));
        expect_row(32'hD000_0001, 32'hD000_0002, 32'hD000_0003, "R7 high index bits ignored");
        run(mk(1, 0, 0, 5));
        expect_row(32'h0, 32'h0, 32'h0, "R8 hashed row 5 untouched");
        run(mk(1, 0, 1, (5 << 2) | 2));
        expect_row(32'h0, 32'h0, 32'h0, "R8 indexed row 22 empty");
        run(mk(1, 0, 0, (5 << 2) | 2));
        expect_row(32'hA000_0001, 32'hA000_0002, 32'hA000_0003, "R8 hashed row 22 intact");

        // R9: all-zero write invalidates
        load(32'h0, 32'h0, 32'h0);
        run(mk(1, 1, 0, (5 << 2) | 1));
        load(32'h5555_5555, 32'h5555_5555, 32'h5555_5555);
        run(mk(1, 0, 0, (5 << 2) | 1));
        expect_row(32'h0, 32'h0, 32'h0, "R9 zero write clears row");

        // R10: writes while busy are ignored
        load(32'hE000_0001, 32'hE000_0002, 32'hE000_0003);
        wr(2'd0, mk(1, 1, 1, 9));
        wr(2'd1, 32'hDEAD_BEEF);
        wr(2'd0, mk(1, 0, 1, 3));
        tick();
        chk(2'd0, mk(0, 1, 1, 9), "R10 command kept while busy");
        expect_row(32'hE000_0001, 32'hE000_0002, 32'hE000_0003, "R10 staging kept while busy");
        load(32'h0, 32'h0, 32'h0);
        run(mk(1, 0, 1, 9));
        expect_row(32'hE000_0001, 32'hE000_0002, 32'hE000_0003, "R10 original data stored");

        // R11: reserved region codes
        load(32'h7777_7777, 32'h8888_8888, 32'h9999_9999);
        run_timed(mk(1, 0, 2, (5 << 2) | 2), "R11 reserved timing");
        expect_row(32'h0, 32'h0, 32'h0, "R11 reserved read zero");
        load(32'hF000_0001, 32'hF000_0002, 32'hF000_0003);
        run(mk(1, 1, 3, (6 << 2) | 2));
        run(mk(1, 0, 0, (6 << 2) | 2));
        expect_row(32'hC000_0001, 32'hC000_0002, 32'hC000_0003, "R11 hashed row unchanged");
        run(mk(1, 0, 1, (6 << 2) | 2));
        expect_row(32'h0, 32'h0, 32'h0, "R11 indexed row unchanged");

        tick();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule